// File: doc/BRIEF.md
# Receive Packet Chain Walker

This block scans the receive area of a packet buffer RAM after a receive event. Each received frame sits behind a four-byte header that points to the header of the frame after it. The headers therefore form a chain that winds through a receive region, and the region wraps from the top of the RAM back to its own base. The block is started with a one-cycle pulse. It picks up the chain at the saved receive pointer and fetches each header as two 16-bit reads through a registered read port. For every completed frame it hands a descriptor (payload byte address and payload length) to a consumer over a valid/ready handshake.

The walk ends cleanly in two cases: at a header whose link is zero, and at a frame that the receiver has not finished. In both cases the saved pointer is left on that header, so the next walk resumes there. A frame with a bad status nibble or an impossible length aborts the walk. A chain longer than the packet limit also aborts it. An abort raises the error output, which tells the surrounding logic to reinitialise the buffer, and the saved pointer returns to the region base. Moving payload bytes, the MAC and the host bus are handled elsewhere.

Top module: `rx_chain_walker`

## Requirements
- R1: After reset, the saved pointer `rx_ptr` is the region base 0x4000 and `rx_end_page` is 0x40. `busy`, `walk_done`, `walk_err` and `desc_valid` are low.
- R2: A header at byte address A is read at word address A>>1 and at word address (A+2, wrapped)>>1. The read data arrives on `mem_rd_data` the cycle after `mem_rd_en`. In the first word, the low byte is the link's most significant byte and the high byte is its least significant byte. The high byte of the second word is the status byte, and its low byte (control) is ignored.
- R3: A header with link value 0 ends the walk whatever its status. It emits no descriptor and leaves `rx_ptr` on that header.
- R4: A header whose status bit 7 (done) is clear ends the walk. It emits no descriptor and leaves `rx_ptr` on that header.
- R5: Payload length = link − A − 4. If that is negative, 0xC000 is added to it.
- R6: Payload address = A + 4. Any byte address of 0x10000 or more wraps to itself minus 0xC000, and the second header word uses the same rule.
- R7: A done header with any of status bits 3..0 set emits no descriptor. It pulses `walk_err` together with `walk_done` and returns `rx_ptr` to 0x4000.
- R8: A length above 1514, or still negative after the correction, is treated as in R7. A length of exactly 1514 is accepted.
- R9: While `desc_valid` is high and `desc_ready` is low, the descriptor holds steady. Each accepted transfer consumes exactly one frame, in chain order.
- R10: When a walk ends without error, `walk_done` pulses and `rx_ptr` holds the first unconsumed header. `rx_end_page` always equals `rx_ptr` shifted right by 8 while idle.
- R11: A frame of length 0 is delivered, and the walk then ends with `rx_ptr` on its link target. The header at that target is not read.
- R12: Once 256 frames have been accepted in a single walk that has not ended, the walk aborts as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_start | input | 1 | One-cycle pulse that starts a walk (ignored while busy) |
| busy | output | 1 | A walk is in progress |
| walk_done | output | 1 | One-cycle pulse when a walk ends |
| walk_err | output | 1 | One-cycle pulse with walk_done when the walk aborted |
| mem_rd_en | output | 1 | Read request to the buffer RAM |
| mem_rd_addr | output | 15 | Word address of the read |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Consumer accepts the descriptor |
| desc_addr | output | 16 | Payload byte address |
| desc_len | output | 16 | Payload length in bytes |
| rx_ptr | output | 16 | Saved receive pointer |
| rx_end_page | output | 8 | Receive-end page value (rx_ptr >> 8) |

## Verification
The hardest states to reach from the ports are the wrap corners and the packet limit. Both need long, legal chains, because any single hop longer than 1514 bytes is itself an error. The stimulus builds these chains with a hop generator that climbs the region in 1500-byte steps. One chain ends in a header at 0xFF00 whose link falls back below the top. Another ends at 0xFFFE, so its second word and its payload both wrap. For the limit, the hop chain closes into a full lap of the region that the walker circles until it has accepted 256 frames. The consumer's ready line is driven pseudo-randomly on long chains, so descriptors are held across stalls.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_LO,
      ST_RD_HI,
      ST_GRAB,
      ST_JUDGE,
      ST_OFFER
   } walk_state_e;

   typedef enum logic [1:0] {
      V_STOP,
      V_FAULT,
      V_TAKE
   } verdict_e;

endpackage

// File: rtl/rxw_addr_wrap.sv
module rxw_addr_wrap #(
   parameter int ADDR_W  = 16,
   parameter int RX_BASE = 'h4000,
   parameter int OFFSET  = 4
) (
   input  logic [ADDR_W-1:0] base_in,
   output logic [ADDR_W-1:0] wrapped
);
   localparam int SW = ADDR_W + 1;

   generate
      if (RX_BASE == 0) begin : g_flat
         assign wrapped = base_in + ADDR_W'(OFFSET);
      end else begin : g_fold
         logic [SW-1:0] sum;
         assign sum = {1'b0, base_in} + SW'(OFFSET);
         // past the top of RAM: drop the carry and re-enter at the region base
         assign wrapped = sum[ADDR_W] ? (sum[ADDR_W-1:0] + ADDR_W'(RX_BASE))
                                      : sum[ADDR_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/rxw_hdr_judge.sv
module rxw_hdr_judge
   import rxw_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int REGION  = 'hC000,
   parameter int MAX_LEN = 1514
) (
   input  logic [ADDR_W-1:0] hdr_addr,
   input  logic [15:0]       link_word,
   input  logic [7:0]        stat_byte,
   output logic [ADDR_W-1:0] next_ptr,
   output logic [ADDR_W-1:0] pkt_len,
   output verdict_e          verdict
);
   localparam int SW       = ADDR_W + 3;
   localparam int DONE_BIT = 7;

   logic [15:0]          link_swapped;
   logic signed [SW-1:0] diff;
   logic signed [SW-1:0] adj;
   logic                 too_long;

   always_comb begin
      link_swapped = {link_word[7:0], link_word[15:8]};
      next_ptr     = link_swapped[ADDR_W-1:0];
      diff         = $signed(SW'(next_ptr)) - $signed(SW'(hdr_addr)) - SW'(4);
      adj          = diff[SW-1] ? (diff + $signed(SW'(REGION))) : diff;
      too_long     = adj[SW-1] || (adj > $signed(SW'(MAX_LEN)));
      pkt_len      = adj[ADDR_W-1:0];
      if (next_ptr == '0 || !stat_byte[DONE_BIT])
         verdict = V_STOP;
      else if (stat_byte[3:0] != 4'h0 || too_long)
         verdict = V_FAULT;
      else
         verdict = V_TAKE;
   end

endmodule

// File: rtl/rx_chain_walker.sv
module rx_chain_walker
   import rxw_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int RX_BASE  = 'h4000,
   parameter int MAX_LEN  = 1514,
   parameter int MAX_PKTS = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              walk_start,
   output logic              busy,
   output logic              walk_done,
   output logic              walk_err,
   output logic              mem_rd_en,
   output logic [ADDR_W-2:0] mem_rd_addr,
   input  logic [15:0]       mem_rd_data,
   output logic              desc_valid,
   input  logic              desc_ready,
   output logic [ADDR_W-1:0] desc_addr,
   output logic [ADDR_W-1:0] desc_len,
   output logic [ADDR_W-1:0] rx_ptr,
   output logic [ADDR_W-9:0] rx_end_page
);
   localparam int SPAN   = 2 ** ADDR_W;
   localparam int REGION = SPAN - RX_BASE;
   localparam int CNT_W  = $clog2(MAX_PKTS + 1);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(RX_BASE);
   localparam logic [CNT_W-1:0]  CAP_V  = CNT_W'(MAX_PKTS);

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
      $error("rx_chain_walker: ADDR_W must lie in 9..16");
   end
   if (RX_BASE < 0 || RX_BASE >= SPAN || RX_BASE % 256 != 0) begin : g_bad_base
      $error("rx_chain_walker: RX_BASE must be page aligned inside the RAM");
   end
   if (MAX_LEN < 1 || MAX_LEN >= REGION) begin : g_bad_len
      $error("rx_chain_walker: MAX_LEN must be positive and below the region size");
   end
   if (MAX_PKTS < 1) begin : g_bad_cap
      $error("rx_chain_walker: MAX_PKTS must be at least one");
   end

   walk_state_e       state;
   logic [ADDR_W-1:0] cur;
   logic [15:0]       link_q;
   logic [7:0]        stat_q;
   logic [CNT_W-1:0]  taken;
   logic [ADDR_W-1:0] hi_addr;
   logic [ADDR_W-1:0] pay_addr;
   logic [ADDR_W-1:0] next_ptr;
   logic [ADDR_W-1:0] pkt_len;
   logic [ADDR_W-1:0] sel_addr;
   logic              unused_lsb;
   verdict_e          verdict;

   rxw_addr_wrap #(.ADDR_W(ADDR_W), .RX_BASE(RX_BASE), .OFFSET(2)) u_hi_wrap (
      .base_in (cur),
      .wrapped (hi_addr)
   );

   rxw_addr_wrap #(.ADDR_W(ADDR_W), .RX_BASE(RX_BASE), .OFFSET(4)) u_pay_wrap (
      .base_in (cur),
      .wrapped (pay_addr)
   );

   rxw_hdr_judge #(.ADDR_W(ADDR_W), .REGION(REGION), .MAX_LEN(MAX_LEN)) u_judge (
      .hdr_addr  (cur),
      .link_word (link_q),
      .stat_byte (stat_q),
      .next_ptr  (next_ptr),
      .pkt_len   (pkt_len),
      .verdict   (verdict)
   );

   always_comb begin
      busy        = (state != ST_IDLE);
      desc_valid  = (state == ST_OFFER);
      mem_rd_en   = (state == ST_RD_LO) || (state == ST_RD_HI);
      sel_addr    = (state == ST_RD_HI) ? hi_addr : cur;
      mem_rd_addr = sel_addr[ADDR_W-1:1];
      unused_lsb  = sel_addr[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cur         <= BASE_V;
         link_q      <= '0;
         stat_q      <= '0;
         taken       <= '0;
         desc_addr   <= '0;
         desc_len    <= '0;
         rx_ptr      <= BASE_V;
         rx_end_page <= BASE_V[ADDR_W-1:8];
         walk_done   <= 1'b0;
         walk_err    <= 1'b0;
      end else begin
         walk_done <= 1'b0;
         walk_err  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (walk_start) begin
                  cur   <= rx_ptr;
                  taken <= '0;
                  state <= ST_RD_LO;
               end
            end
            ST_RD_LO: state <= ST_RD_HI;
            ST_RD_HI: begin
               link_q <= mem_rd_data;
               state  <= ST_GRAB;
            end
            ST_GRAB: begin
               stat_q <= mem_rd_data[15:8];
               state  <= ST_JUDGE;
            end
            ST_JUDGE: begin
               case (verdict)
                  V_TAKE: begin
                     desc_addr <= pay_addr;
                     desc_len  <= pkt_len;
                     state     <= ST_OFFER;
                  end
                  V_FAULT: begin
                     rx_ptr      <= BASE_V;
                     rx_end_page <= BASE_V[ADDR_W-1:8];
                     walk_done   <= 1'b1;
                     walk_err    <= 1'b1;
                     state       <= ST_IDLE;
                  end
                  default: begin
                     rx_ptr      <= cur;
                     rx_end_page <= cur[ADDR_W-1:8];
                     walk_done   <= 1'b1;
                     state       <= ST_IDLE;
                  end
               endcase
            end
            ST_OFFER: begin
               if (desc_ready) begin
                  taken <= taken + CNT_W'(1);
                  cur   <= next_ptr;
                  if (desc_len == '0) begin
                     rx_ptr      <= next_ptr;
                     rx_end_page <= next_ptr[ADDR_W-1:8];
                     walk_done   <= 1'b1;
                     state       <= ST_IDLE;
                  end else if (taken + CNT_W'(1) == CAP_V) begin
                     rx_ptr      <= BASE_V;
                     rx_end_page <= BASE_V[ADDR_W-1:8];
                     walk_done   <= 1'b1;
                     walk_err    <= 1'b1;
                     state       <= ST_IDLE;
                  end else begin
                     state <= ST_RD_LO;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // descriptor must not move while the consumer stalls
   assert_desc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_addr) && $stable(desc_len)));

   // the page register tracks the saved pointer whenever the walker rests
   assert_page_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rx_end_page == rx_ptr[ADDR_W-1:8]));

   // an abort always ends the walk and rewinds to the region base
   assert_fault_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      walk_err |-> (walk_done && rx_ptr == BASE_V));

   // no oversized frame ever reaches the consumer
   assert_len_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> (desc_len <= ADDR_W'(MAX_LEN)));

   // header reads stay inside the receive region
   assert_rd_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> ({mem_rd_addr, 1'b0} >= BASE_V));

   // end of walk leaves the block quiet
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |-> (!busy && !desc_valid && !mem_rd_en));

   // frame counter never passes the per-walk limit
   assert_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      taken <= CAP_V);

endmodule

// File: tb/rx_chain_walker_tb.sv
module rx_chain_walker_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        walk_start;
   logic        busy, walk_done, walk_err;
   logic        mem_rd_en;
   logic [14:0] mem_rd_addr;
   logic [15:0] mem_rd_data;
   logic        desc_valid;
   logic        desc_ready;
   logic [15:0] desc_addr, desc_len;
   logic [15:0] rx_ptr;
   logic [7:0]  rx_end_page;

   always #5 clk = ~clk;

   rx_chain_walker u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .walk_start  (walk_start),
      .busy        (busy),
      .walk_done   (walk_done),
      .walk_err    (walk_err),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data),
      .desc_valid  (desc_valid),
      .desc_ready  (desc_ready),
      .desc_addr   (desc_addr),
      .desc_len    (desc_len),
      .rx_ptr      (rx_ptr),
      .rx_end_page (rx_end_page)
   );

   logic [15:0] mem [0:32767];
   int          total = 0;
   int          bad = 0;
   int          exp_addr_q[$];
   int          exp_len_q[$];
   int          exp_ptr;
   bit          exp_err;
   int          cur_ptr = 'h4000;
   bit          rand_ready = 1'b0;
   logic [7:0]  lfsr = 8'h5B;

   // registered RAM model: data one cycle after the request (R2)
   initial begin
      mem_rd_data = 16'h0;
      forever begin
         @(posedge clk);
         if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
      end
   end

   function automatic int wrapb(int x);
      return (x >= 65536) ? x - 'hC000 : x;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // first word: low byte = link MSB, high byte = link LSB; second word high byte = status
   task automatic put_hdr(int a, int nxt, int st);
      mem[a >> 1] = {nxt[7:0], nxt[15:8]};
      mem[wrapb(a + 2) >> 1] = {st[7:0], 8'hC3};
   endtask

   task automatic build_hops(int from, int to);
      int a = from;
      while (to - a > 'h5E4) begin
         put_hdr(a, a + 'h5E0, 'h80);
         a += 'h5E0;
      end
      put_hdr(a, to, 'h80);
   endtask

   // behavioural reference: expected descriptors, end pointer and error
   function automatic void model(int start);
      int a = start;
      int n = 0;
      exp_err = 1'b0;
      exp_addr_q.delete();
      exp_len_q.delete();
      forever begin
         logic [15:0] w0, w1;
         int nxt, st, len;
         w0  = mem[a >> 1];
         w1  = mem[wrapb(a + 2) >> 1];
         nxt = {w0[7:0], w0[15:8]};
         st  = w1[15:8];
         if (nxt == 0 || st[7] == 1'b0) break;
         len = nxt - a - 4;
         if (len < 0) len += 'hC000;
         if (st[3:0] != 0 || len < 0 || len > 1514) begin
            exp_err = 1'b1;
            break;
         end
         exp_addr_q.push_back(wrapb(a + 4));
         exp_len_q.push_back(len);
         n++;
         a = nxt;
         if (len == 0) break;
         if (n == 256) begin
            exp_err = 1'b1;
            break;
         end
      end
      exp_ptr = exp_err ? 'h4000 : a;
   endfunction

   // consumer: drives ready at each falling edge and checks accepted descriptors
   initial begin
      bit hold_v = 1'b0;
      int hold_a = 0;
      int hold_l = 0;
      desc_ready = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (rand_ready) begin
               lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
               desc_ready = lfsr[0] | lfsr[3];
            end else begin
               desc_ready = 1'b1;
            end
            if (hold_v)
               check(desc_valid && desc_addr == hold_a[15:0] && desc_len == hold_l[15:0],
                     "R9", "descriptor held over stall", int'(desc_addr), hold_a);
            if (desc_valid && desc_ready) begin
               if (exp_addr_q.size() == 0) begin
                  check(1'b0, "R9", "unexpected descriptor", int'(desc_addr), 0);
               end else begin
                  check(int'(desc_addr) == exp_addr_q[0], "R6", "payload address",
                        int'(desc_addr), exp_addr_q[0]);
                  check(int'(desc_len) == exp_len_q[0], "R5", "payload length",
                        int'(desc_len), exp_len_q[0]);
                  void'(exp_addr_q.pop_front());
                  void'(exp_len_q.pop_front());
               end
            end
            hold_v = desc_valid && !desc_ready;
            hold_a = int'(desc_addr);
            hold_l = int'(desc_len);
         end
      end
   end

   task automatic run_walk(string req);
      int n = 0;
      model(cur_ptr);
      walk_start = 1'b1;
      @(negedge clk);
      walk_start = 1'b0;
      while (!walk_done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(walk_done, req, "walk ended", int'(walk_done), 1);
      check(walk_err == exp_err, req, "error flag", int'(walk_err), int'(exp_err));
      check(int'(rx_ptr) == exp_ptr, "R10", "saved pointer", int'(rx_ptr), exp_ptr);
      check(int'(rx_end_page) == (exp_ptr >> 8), "R10", "end page",
            int'(rx_end_page), exp_ptr >> 8);
      check(exp_addr_q.size() == 0, req, "descriptors outstanding",
            exp_addr_q.size(), 0);
      cur_ptr = exp_ptr;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32768; i++) mem[i] = 16'h0;
      rst_n = 1'b0;
      walk_start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(rx_ptr == 16'h4000, "R1", "reset pointer", int'(rx_ptr), 'h4000);
      check(rx_end_page == 8'h40, "R1", "reset page", int'(rx_end_page), 'h40);
      check(!busy && !walk_done && !walk_err && !desc_valid, "R1", "idle outputs",
            int'({busy, walk_done, walk_err, desc_valid}), 0);

      // R3: null header, even with done set
      put_hdr('h4000, 0, 'h80);
      run_walk("R3");

      // R2: three-frame chain through the byte-swapped link, with stalls
      rand_ready = 1'b1;
      put_hdr('h4000, 'h4040, 'h80);
      put_hdr('h4040, 'h4100, 'h80);
      put_hdr('h4100, 'h4200, 'h80);
      put_hdr('h4200, 0, 0);
      run_walk("R2");

      // R4: frame still being received, then completed
      put_hdr('h4200, 'h4300, 'h00);
      run_walk("R4");
      put_hdr('h4200, 'h4300, 'h80);
      put_hdr('h4300, 0, 0);
      run_walk("R4");

      // R8 boundary 1514, then R5 negative-length correction at 0xFF00
      put_hdr('h4300, 'h48EE, 'h80);
      build_hops('h48EE, 'hFF00);
      put_hdr('hFF00, 'h4050, 'h80);
      put_hdr('h4050, 0, 0);
      run_walk("R8");

      // R6: header at 0xFFFE, second word and payload wrap
      build_hops('h4050, 'hFFFE);
      put_hdr('hFFFE, 'h4100, 'h80);
      put_hdr('h4100, 0, 0);
      run_walk("R6");
      rand_ready = 1'b0;

      // R8: length 1515 aborts after one good frame
      put_hdr('h4100, 'h4180, 'h80);
      put_hdr('h4180, 'h4180 + 4 + 1515, 'h80);
      run_walk("R8");

      // R7: status error nibble aborts
      put_hdr('h4000, 'h4080, 'h80);
      put_hdr('h4080, 'h4100, 'h82);
      run_walk("R7");

      // R11: zero-length frame ends the walk at its link target
      put_hdr('h4000, 'h4004, 'h80);
      put_hdr('h4004, 'h4040, 'h80);
      run_walk("R11");

      // R12: closed loop around the region hits the frame limit
      build_hops('h4004, 'hFF00);
      put_hdr('hFF00, 'h4004, 'h80);
      run_walk("R12");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule